// File: doc/BRIEF.md
# Q15 Radix-2 Butterfly Datapath

This block computes one radix-2 decimation-in-time FFT butterfly on complex signed 16-bit Q15 samples. Each clock it can accept a pair of complex operands x and y together with a complex twiddle factor W. It returns the sum output a = x + y·W and the difference output b = x − y·W. Twiddle storage, stage addressing, reordering and inter-stage scaling are handled elsewhere. The block is only the arithmetic core that an FFT sequencer feeds once per butterfly.

The four twiddle products are formed first. Each signed 32-bit product is brought back to Q15 in two steps. The product's upper half is held for one cycle and shifted left by one bit. The sign bit of the product's lower half, captured together with the multiply, fills the vacated least significant bit. The x operands travel through matching delay registers so that they meet the realigned products at the final add/subtract stage.

A valid bit follows the data through the three pipeline registers. Results appear three cycles after the inputs, and a new butterfly can start every cycle.

Top module: `q15_butterfly`

## Requirements
- R1: aRe equals xRe + Q(yRe·wRe) − Q(yIm·wIm), where Q(p) is bits 30 down to 15 of the signed 32-bit product p. The result is taken modulo 2^16.
- R2: aIm equals xIm + Q(yRe·wIm) + Q(yIm·wRe), modulo 2^16.
- R3: bRe equals xRe − Q(yRe·wRe) + Q(yIm·wIm), and bIm equals xIm − Q(yRe·wIm) − Q(yIm·wRe), both modulo 2^16.
- R4: The product of 0x8000 and 0x8000 realigns to 0x8000 (wraparound, no saturation). With x = 0, yRe = wRe = 0x8000 and yIm = wIm = 0, the outputs are aRe = bRe = 0x8000 and aIm = bIm = 0.
- R5: Additions and subtractions wrap in 16 bits, with no halving and no saturation. For example, xRe = 0x7FFF plus a realigned product of 0x3FFF gives aRe = 0xBFFE.
- R6: outValid is high in exactly the third cycle after the clock edge that sampled inValid high, and the data outputs carry that butterfly's result in that cycle.
- R7: Inputs offered with inValid high on consecutive cycles each yield exactly one result, in the same order, on consecutive cycles.
- R8: A synchronous active-high rst clears every pipeline valid bit and zeroes the output data. Operands sampled before or during reset produce no outValid pulse afterwards.
- R9: While outValid is low, aRe, aIm, bRe and bIm keep the value of the most recent result.
- R10: Realignment truncates toward minus infinity. 0xFFFF·0x0001 realigns to 0xFFFF, and 0x0001·0x0001 realigns to 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands on the input ports are valid this cycle |
| xRe | input | 16 | Real part of x, Q15 |
| xIm | input | 16 | Imaginary part of x, Q15 |
| yRe | input | 16 | Real part of y, Q15 |
| yIm | input | 16 | Imaginary part of y, Q15 |
| wRe | input | 16 | Real part of twiddle W, Q15 |
| wIm | input | 16 | Imaginary part of twiddle W, Q15 |
| outValid | output | 1 | Butterfly result valid this cycle |
| aRe | output | 16 | Real part of x + y·W, Q15 |
| aIm | output | 16 | Imaginary part of x + y·W, Q15 |
| bRe | output | 16 | Real part of x − y·W, Q15 |
| bIm | output | 16 | Imaginary part of x − y·W, Q15 |

## Verification
A table of hand-computed butterflies drives each product term alone or in pairs. These vectors catch a swapped operand, a wrong sign on one of the eight add/subtract terms, or a cross-term routed to the wrong output. Extreme operands separate correct realignment from an off-by-one bit slice or a saturating variant. These include 0x8000·0x8000, full-scale 0x7FFF values, −1·1 against 1·1 truncation, and sums that overflow past 0x7FFF. Long random streams, some back to back and some with idle gaps, are compared with a bit-exact model. They expose pipeline misalignment between the delayed x and the products, a wrong latency, and outputs that change while no result is valid. A reset applied while the pipeline is full shows whether stale operands leak out.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // Number of register stages from input sample to result.
  localparam int PIPE_DEPTH = 3;

  // Number of real twiddle products per butterfly.
  localparam int NUM_PROD = 4;

  // Per-stage load strobes handed from control to datapath.
  typedef struct packed {
    logic capMul;    // stage 1: multiply, x first delay
    logic capAlign;  // stage 2: realign, x second delay
    logic capSum;    // stage 3: add/subtract into outputs
  } bflyStrobe_t;

endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import bfly_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output bflyStrobe_t strobe,
  output logic        outValid
);

  logic [PIPE_DEPTH-1:0] vldQ;

  always_ff @(posedge clk) begin
    if (rst) vldQ[0] <= 1'b0;
    else     vldQ[0] <= inValid;
  end

  genvar s;
  generate
    for (s = 1; s < PIPE_DEPTH; s++) begin : g_vld
      always_ff @(posedge clk) begin
        if (rst) vldQ[s] <= 1'b0;
        else     vldQ[s] <= vldQ[s-1];
      end
    end
  endgenerate

  always_comb begin
    strobe.capMul   = inValid;
    strobe.capAlign = vldQ[0];
    strobe.capSum   = vldQ[1];
  end

  assign outValid = vldQ[PIPE_DEPTH-1];

  // R6: every result traces back to an accepted input three cycles earlier
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 3));

endmodule

// File: rtl/bfly_mul_align.sv
module bfly_mul_align #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                capMul,
  input  logic                capAlign,
  input  logic signed [W-1:0] opA,
  input  logic signed [W-1:0] opB,
  output logic        [W-1:0] aligned
);

  localparam int PW = 2 * W;

  logic signed [PW-1:0] prod;
  logic        [W-1:0]  hiQ;
  logic                 loMsbQ;
  logic        [W-2:0]  lowUnused;
  logic                 topUnused;

  assign prod      = opA * opB;
  assign lowUnused = prod[W-2:0];
  assign topUnused = hiQ[W-1];

  // Stage 1: upper half registered, lower-half sign bit captured alongside.
  always_ff @(posedge clk) begin
    if (capMul) begin
      hiQ    <= prod[PW-1:W];
      loMsbQ <= prod[W-1];
    end
  end

  // Stage 2: delayed upper half shifted left, lower MSB inserted as LSB.
  always_ff @(posedge clk) begin
    if (capAlign) aligned <= {hiQ[W-2:0], loMsbQ};
  end

endmodule

// File: rtl/bfly_datapath.sv
module bfly_datapath
  import bfly_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  bflyStrobe_t strobe,
  input  logic [W-1:0] xRe,
  input  logic [W-1:0] xIm,
  input  logic [W-1:0] yRe,
  input  logic [W-1:0] yIm,
  input  logic [W-1:0] wRe,
  input  logic [W-1:0] wIm,
  output logic [W-1:0] aRe,
  output logic [W-1:0] aIm,
  output logic [W-1:0] bRe,
  output logic [W-1:0] bIm
);

  // Product index: 0 = yRe*wRe, 1 = yIm*wIm, 2 = yRe*wIm, 3 = yIm*wRe
  logic signed [W-1:0] mulA [NUM_PROD];
  logic signed [W-1:0] mulB [NUM_PROD];
  logic        [W-1:0] prodQ [NUM_PROD];

  assign mulA[0] = yRe;  assign mulB[0] = wRe;
  assign mulA[1] = yIm;  assign mulB[1] = wIm;
  assign mulA[2] = yRe;  assign mulB[2] = wIm;
  assign mulA[3] = yIm;  assign mulB[3] = wRe;

  genvar g;
  generate
    for (g = 0; g < NUM_PROD; g++) begin : g_mul
      bfly_mul_align #(.W(W)) i_mul (
        .clk      (clk),
        .capMul   (strobe.capMul),
        .capAlign (strobe.capAlign),
        .opA      (mulA[g]),
        .opB      (mulB[g]),
        .aligned  (prodQ[g])
      );
    end
  endgenerate

  // x delay line matching the two product stages
  logic [W-1:0] xReD1, xImD1, xReD2, xImD2;

  always_ff @(posedge clk) begin
    if (strobe.capMul) begin
      xReD1 <= xRe;
      xImD1 <= xIm;
    end
    if (strobe.capAlign) begin
      xReD2 <= xReD1;
      xImD2 <= xImD1;
    end
  end

  // Stage 3: wraparound add/subtract, outputs cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      aRe <= '0;
      aIm <= '0;
      bRe <= '0;
      bIm <= '0;
    end else if (strobe.capSum) begin
      aRe <= xReD2 + prodQ[0] - prodQ[1];
      aIm <= xImD2 + prodQ[2] + prodQ[3];
      bRe <= xReD2 - prodQ[0] + prodQ[1];
      bIm <= xImD2 - prodQ[2] - prodQ[3];
    end
  end

  logic [W-1:0] pairRe, pairIm;
  assign pairRe = aRe + bRe;
  assign pairIm = aIm + bIm;

  // R1 / R3: real sum and difference outputs add up to twice the delayed x
  p_real_pair_r1: assert property (@(posedge clk) disable iff (rst)
    strobe.capSum |=> pairRe == {$past(xReD2[W-2:0]), 1'b0});

  // R2 / R3: the same holds for the imaginary outputs
  p_imag_pair_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.capSum |=> pairIm == {$past(xImD2[W-2:0]), 1'b0});

  // R9: outputs are held when no result is written
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strobe.capSum |=> $stable({aRe, aIm, bRe, bIm}));

endmodule

// File: rtl/q15_butterfly.sv
module q15_butterfly
  import bfly_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] xRe,
  input  logic [DATA_W-1:0] xIm,
  input  logic [DATA_W-1:0] yRe,
  input  logic [DATA_W-1:0] yIm,
  input  logic [DATA_W-1:0] wRe,
  input  logic [DATA_W-1:0] wIm,
  output logic              outValid,
  output logic [DATA_W-1:0] aRe,
  output logic [DATA_W-1:0] aIm,
  output logic [DATA_W-1:0] bRe,
  output logic [DATA_W-1:0] bIm
);

  bflyStrobe_t strobe;

  bfly_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  bfly_datapath #(.W(DATA_W)) i_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .xRe    (xRe),
    .xIm    (xIm),
    .yRe    (yRe),
    .yIm    (yIm),
    .wRe    (wRe),
    .wIm    (wIm),
    .aRe    (aRe),
    .aIm    (aIm),
    .bRe    (bRe),
    .bIm    (bIm)
  );

endmodule

// File: tb/test_q15_butterfly.sv
`timescale 1ns/1ps
module test_q15_butterfly;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [15:0] xRe = '0, xIm = '0, yRe = '0, yIm = '0, wRe = '0, wIm = '0;
  logic outValid;
  logic [15:0] aRe, aIm, bRe, bIm;

  always #4 clk = ~clk;  // 125 MHz

  q15_butterfly i_q15_butterfly (
    .clk(clk), .rst(rst), .inValid(inValid),
    .xRe(xRe), .xIm(xIm), .yRe(yRe), .yIm(yIm), .wRe(wRe), .wIm(wIm),
    .outValid(outValid), .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm)
  );

  int chkCnt = 0;
  int errCnt = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // {xRe, xIm, yRe, yIm, wRe, wIm, aRe, aIm, bRe, bIm}
  localparam int N_TAB = 8;
  localparam logic [159:0] TAB [N_TAB] = '{
    {16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000, 16'h0000,16'h0000,16'h0000,16'h0000},
    {16'h1000,16'h2000,16'h0000,16'h0000,16'h7FFF,16'h0000, 16'h1000,16'h2000,16'h1000,16'h2000},
    {16'h0000,16'h0000,16'h8000,16'h0000,16'h8000,16'h0000, 16'h8000,16'h0000,16'h8000,16'h0000},
    {16'h0000,16'h0000,16'h4000,16'h0000,16'h4000,16'h0000, 16'h2000,16'h0000,16'hE000,16'h0000},
    {16'h7FFF,16'h0000,16'h4000,16'h0000,16'h7FFF,16'h0000, 16'hBFFE,16'h0000,16'h4000,16'h0000},
    {16'h0000,16'h0000,16'hFFFF,16'h0001,16'h0001,16'h0001, 16'hFFFF,16'hFFFF,16'h0001,16'h0001},
    {16'h0100,16'h0200,16'h4000,16'h4000,16'h0000,16'h4000, 16'hE100,16'h2200,16'h2100,16'hE200},
    {16'h0000,16'h0000,16'h7FFF,16'h8000,16'h7FFF,16'h0000, 16'h7FFE,16'h8001,16'h8002,16'h7FFF}
  };
  localparam string TAB_REQ [N_TAB] = '{"R1", "R3", "R4", "R2", "R5", "R10", "R2", "R1"};

  // Expected-result queue filled by the driver, consumed by the monitor
  logic [63:0] expQ [1024];
  int          sendCyc [1024];
  string       expReq [1024];
  int sent = 0;
  int got = 0;
  bit monOn = 0;
  bit haveLast = 0;
  logic [63:0] lastOut;

  function automatic logic [15:0] q15(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] p;
    p = $signed(a) * $signed(b);
    return p[30:15];
  endfunction

  function automatic logic [63:0] refBfly(input logic [15:0] xr, xi, yr, yi, wr, wi);
    logic [15:0] rr, ii, ri, ir;
    rr = q15(yr, wr); ii = q15(yi, wi); ri = q15(yr, wi); ir = q15(yi, wr);
    return {16'(xr + rr - ii), 16'(xi + ri + ir), 16'(xr - rr + ii), 16'(xi - ri - ir)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input logic [15:0] xr, xi, yr, yi, wr, wi,
                      input logic [63:0] exp, input string req);
    @(negedge clk);
    xRe = xr; xIm = xi; yRe = yr; yIm = yi; wRe = wr; wIm = wi;
    inValid = 1'b1;
    expQ[sent] = exp;
    sendCyc[sent] = cyc;
    expReq[sent] = req;
    sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  function automatic logic [15:0] pickOp();
    case ($urandom % 8)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  // Monitor: compares results away from the active edge
  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        if (got < sent) begin
          check(expReq[got], {aRe, aIm, bRe, bIm}, expQ[got]);
          check("R6", 64'(cyc - sendCyc[got]), 64'd3);
        end else begin
          check("R7", 64'(got), 64'(sent - 1));
        end
        lastOut = {aRe, aIm, bRe, bIm};
        haveLast = 1;
        got++;
      end else if (haveLast) begin
        check("R9", {aRe, aIm, bRe, bIm}, lastOut);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", {63'd0, outValid}, 64'd0);
    check("R8", {aRe, aIm, bRe, bIm}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R8", {63'd0, outValid}, 64'd0);
    monOn = 1;

    // Table walk, back to back (R7)
    for (int i = 0; i < N_TAB; i++)
      push(TAB[i][159:144], TAB[i][143:128], TAB[i][127:112], TAB[i][111:96],
           TAB[i][95:80], TAB[i][79:64], TAB[i][63:0], TAB_REQ[i]);
    idle(6);
    check("R7", 64'(got), 64'(sent));

    // Random stream, back-to-back bursts and gaps (R1, R2, R3, R7, R9)
    for (int i = 0; i < 400; i++) begin
      logic [15:0] v [6];
      for (int k = 0; k < 6; k++) v[k] = pickOp();
      push(v[0], v[1], v[2], v[3], v[4], v[5],
           refBfly(v[0], v[1], v[2], v[3], v[4], v[5]), "R1/R2/R3 random");
      if ($urandom % 5 == 0) idle(1 + ($urandom % 3));
    end
    idle(6);
    check("R7", 64'(got), 64'(sent));

    // R8: reset with a full pipeline and inValid held high
    monOn = 0;
    haveLast = 0;
    @(negedge clk);
    inValid = 1'b1; xRe = 16'h1234; yRe = 16'h7FFF; wRe = 16'h7FFF;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      check("R8", {63'd0, outValid}, 64'd0);
      check("R8", {aRe, aIm, bRe, bIm}, 64'd0);
      @(negedge clk);
    end

    // After reset, single isolated butterfly still works (R6, R4)
    got = sent;
    monOn = 1;
    push(16'h0000, 16'h0000, 16'h8000, 16'h0000, 16'h8000, 16'h0000,
         {16'h8000, 16'h0000, 16'h8000, 16'h0000}, "R4");
    idle(6);
    check("R7", 64'(got), 64'(sent));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", chkCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", chkCnt, errCnt);
      $finish;
    end
  end

endmodule